// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the arithmetic side unit of a small 32-bit integer core. It holds two result registers, HI and LO, and carries out four kinds of work on a pair of operands: a signed or unsigned multiply whose double-width product is split across HI (upper half) and LO (lower half), a signed or unsigned divide that leaves the quotient in LO and the remainder in HI, and direct loads of HI or LO from the first operand. The core reads HI or LO back through a select-and-read path. If it tries to read while a divide is still running, the unit asks it to stall.

A multiply finishes in the cycle it is issued. The unit takes the magnitude of each operand and splits it into two halves. It forms the product from three half-width products: high times high, low times low, and a cross term built from the two half differences. The carry out of the low word is recovered explicitly and added into the high word. For a signed multiply with operands of opposite sign, the unit negates the double-width pair: LO is negated, HI is inverted, and HI is incremented when the new LO is zero. A divide runs one restoring step per cycle on operand magnitudes and then applies a sign fix-up step.

The control is a three-state machine. IDLE accepts operations. DIVIDE runs one quotient bit per cycle. FIXUP applies the signs and writes HI and LO. The transitions are as follows. IDLE goes to DIVIDE when a divide is accepted. IDLE stays in IDLE for any other operation. DIVIDE stays in DIVIDE until the last step, then goes to FIXUP. FIXUP always goes back to IDLE.

Top module: `md_hilo_unit`

## Requirements
- R1: After reset, hi_q and lo_q are zero and busy is low.
- R2: Operation codes are: 1 signed multiply, 2 unsigned multiply, 3 signed divide, 4 unsigned divide, 5 load HI, 6 load LO. An operation is accepted on a clock edge where op_valid is high and busy is low.
- R3: An accepted unsigned multiply sets {hi_q, lo_q} to op_a·op_b. The result is visible one cycle later, and busy stays low.
- R4: An accepted signed multiply sets {hi_q, lo_q} to the two's complement product of the signed operands. The result is visible one cycle later.
- R5: An accepted unsigned divide with a non-zero divisor holds busy high for exactly WIDTH+1 cycles. It then leaves the quotient in lo_q and the remainder in hi_q.
- R6: A signed divide truncates toward zero, and the remainder takes the sign of the dividend. Most-negative divided by −1 gives lo_q equal to the most-negative value and hi_q equal to 0. The timing is the same as R5.
- R7: Load HI copies op_a into hi_q, and load LO copies op_a into lo_q. In both cases the other register is unchanged.
- R8: A divide by zero still releases busy after WIDTH+1 cycles.
- R9: An operation presented while busy is high is ignored: hi_q and lo_q keep their values until the running divide writes them.
- R10: Codes 0 and 7 leave hi_q and lo_q unchanged.
- R11: rd_stall is high when rd_req is high while busy is high. When busy is low, rd_stall is low and rd_data shows hi_q if rd_sel is 1, otherwise lo_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | Operation selector |
| op_a | input | WIDTH | First operand (dividend / load source) |
| op_b | input | WIDTH | Second operand (divisor) |
| busy | output | 1 | Divide in progress |
| hi_q | output | WIDTH | HI register |
| lo_q | output | WIDTH | LO register |
| rd_req | input | 1 | Read of HI or LO requested |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_data | output | WIDTH | Selected register value |
| rd_stall | output | 1 | Read must wait |

## Verification
A wrong carry or cross term in the multiply shows up in hi_q on the next cycle for particular operand pairs. The bench therefore sweeps every operand pair of a 6-bit configuration, both signed and unsigned. A miscounting divide state machine shows up as a busy window longer or shorter than WIDTH+1 cycles, and a faulty step or sign fix-up shows up in lo_q or hi_q on the cycle busy falls. Every non-zero divisor is swept the same way. A register that is written when it should not be is caught on the cycle right after the ignored operation.

// File: rtl/md_pkg.sv
package md_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_MULS = 3'd1,
        OP_MULU = 3'd2,
        OP_DIVS = 3'd3,
        OP_DIVU = 3'd4,
        OP_LDHI = 3'd5,
        OP_LDLO = 3'd6,
        OP_RSVD = 3'd7
    } md_op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DIVIDE = 2'd1,
        S_FIXUP  = 2'd2
    } md_state_e;
endpackage

// File: rtl/md_mul3.sv
module md_mul3 #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_signed,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    localparam int H = WIDTH / 2;

    logic             neg;
    logic [WIDTH-1:0] ma, mb;
    logic [H-1:0]     u1, u0, v1, v0;
    logic [WIDTH-1:0] p_hh, p_ll;
    logic signed [WIDTH+1:0] du, dv, t2, mid_s;
    logic [WIDTH:0]   mid;
    logic [WIDTH:0]   lo_sum;
    logic             carry;
    logic [WIDTH-1:0] plo, phi;

    always_comb begin
        neg = is_signed & (a[WIDTH-1] ^ b[WIDTH-1]);
        ma  = (is_signed && a[WIDTH-1]) ? -a : a;
        mb  = (is_signed && b[WIDTH-1]) ? -b : b;
        u1  = ma[WIDTH-1:H];
        u0  = ma[H-1:0];
        v1  = mb[WIDTH-1:H];
        v0  = mb[H-1:0];
        // three half-width products
        p_hh = {{H{1'b0}}, u1} * {{H{1'b0}}, v1};
        p_ll = {{H{1'b0}}, u0} * {{H{1'b0}}, v0};
        du   = $signed({{(H+2){1'b0}}, u1}) - $signed({{(H+2){1'b0}}, u0});
        dv   = $signed({{(H+2){1'b0}}, v0}) - $signed({{(H+2){1'b0}}, v1});
        t2   = du * dv;
        // middle term equals u1*v0 + u0*v1, never negative
        mid_s  = $signed({2'b00, p_hh}) + $signed({2'b00, p_ll}) + t2;
        mid    = mid_s[WIDTH:0];
        lo_sum = {1'b0, p_ll} + {1'b0, mid[H-1:0], {H{1'b0}}};
        carry  = lo_sum[WIDTH];
        plo    = lo_sum[WIDTH-1:0];
        phi    = p_hh + {{(H-1){1'b0}}, mid[WIDTH:H]} + {{(WIDTH-1){1'b0}}, carry};
        // negate across the pair
        lo = neg ? -plo : plo;
        hi = neg ? (~phi + ((plo == '0) ? WIDTH'(1) : WIDTH'(0))) : phi;
    end
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quot,
    output logic [WIDTH-1:0] rem
);
    logic [WIDTH-1:0] q_r, d_r;
    logic [WIDTH:0]   r_r, r_sh, diff;

    always_comb begin
        r_sh = {r_r[WIDTH-1:0], q_r[WIDTH-1]};
        diff = r_sh - {1'b0, d_r};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
            d_r <= '0;
            r_r <= '0;
        end else if (load) begin
            q_r <= dividend;
            d_r <= divisor;
            r_r <= '0;
        end else if (step) begin
            if (!diff[WIDTH]) begin
                r_r <= diff;
                q_r <= {q_r[WIDTH-2:0], 1'b1};
            end else begin
                r_r <= r_sh;
                q_r <= {q_r[WIDTH-2:0], 1'b0};
            end
        end
    end

    assign quot = q_r;
    assign rem  = r_r[WIDTH-1:0];
endmodule

// File: rtl/md_hilo_unit.sv
module md_hilo_unit
    import md_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic [WIDTH-1:0] hi_q,
    output logic [WIDTH-1:0] lo_q,
    input  logic             rd_req,
    input  logic             rd_sel,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_stall
);
    localparam int CW = $clog2(WIDTH + 1);

    md_state_e        state, state_nx;
    md_op_e           op;
    logic [CW-1:0]    cnt;
    logic             accept, is_div, div_sgn;
    logic             neg_q, neg_r;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [WIDTH-1:0] m_hi, m_lo, quot, rem;

    assign op      = md_op_e'(op_code);
    assign accept  = op_valid && (state == S_IDLE);
    assign div_sgn = (op == OP_DIVS);
    assign is_div  = (op == OP_DIVS) || (op == OP_DIVU);
    assign mag_a   = (div_sgn && op_a[WIDTH-1]) ? -op_a : op_a;
    assign mag_b   = (div_sgn && op_b[WIDTH-1]) ? -op_b : op_b;

    md_mul3 #(.WIDTH(WIDTH)) u_mul (
        .a(op_a), .b(op_b), .is_signed(op == OP_MULS),
        .hi(m_hi), .lo(m_lo)
    );

    md_div_core #(.WIDTH(WIDTH)) u_div (
        .clk(clk), .rst_n(rst_n),
        .load(accept && is_div), .step(state == S_DIVIDE),
        .dividend(mag_a), .divisor(mag_b),
        .quot(quot), .rem(rem)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (accept && is_div) state_nx = S_DIVIDE;
            S_DIVIDE: if (cnt == CW'(WIDTH - 1)) state_nx = S_FIXUP;
            S_FIXUP:  state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state == S_DIVIDE) ? cnt + CW'(1) : '0;
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (accept) begin
                    unique case (op)
                        OP_MULS, OP_MULU: begin
                            hi_q <= m_hi;
                            lo_q <= m_lo;
                        end
                        OP_DIVS, OP_DIVU: begin
                            neg_q <= div_sgn && (op_a[WIDTH-1] ^ op_b[WIDTH-1]);
                            neg_r <= div_sgn && op_a[WIDTH-1];
                        end
                        OP_LDHI: hi_q <= op_a;
                        OP_LDLO: lo_q <= op_a;
                        default: ;
                    endcase
                end
                S_FIXUP: begin
                    lo_q <= neg_q ? -quot : quot;
                    hi_q <= neg_r ? -rem : rem;
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign rd_stall = rd_req && busy;
    assign rd_data  = rd_sel ? hi_q : lo_q;
endmodule

// File: rtl/md_hilo_chk.sv
module md_hilo_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [WIDTH-1:0] op_a,
    input logic             busy,
    input logic [WIDTH-1:0] hi_q,
    input logic [WIDTH-1:0] lo_q,
    input logic             rd_req,
    input logic             rd_stall
);
    logic [31:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run <= '0;
        else        run <= busy ? run + 32'd1 : '0;
    end

    // R3
    mul_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && (op_code == 3'd1 || op_code == 3'd2)) |=> !busy);

    // R5
    div_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && (op_code == 3'd3 || op_code == 3'd4)) |=> busy);

    // R8
    busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run <= WIDTH + 1);

    // R7
    load_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == 3'd5) |=> (hi_q == $past(op_a)) && $stable(lo_q));

    // R9
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(hi_q) && $stable(lo_q)) || !busy);

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy) |-> rd_stall);
endmodule

bind md_hilo_unit md_hilo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .busy(busy), .hi_q(hi_q), .lo_q(lo_q),
    .rd_req(rd_req), .rd_stall(rd_stall)
);

// File: tb/test_md_hilo_unit.sv
module test_md_hilo_unit;
    localparam int W = 6;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [2:0]   op_code = 3'd0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         busy;
    logic [W-1:0] hi_q, lo_q, rd_data;
    logic         rd_req = 1'b0, rd_sel = 1'b0, rd_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    md_hilo_unit #(.WIDTH(W)) i_md_hilo_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .busy(busy), .hi_q(hi_q), .lo_q(lo_q),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .rd_stall(rd_stall)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic longint sx(input int v);
        return (v >= M/2) ? longint'(v - M) : longint'(v);
    endfunction

    task automatic issue(input int code, input int a, input int b);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'(code); op_a = W'(a); op_b = W'(b);
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        longint p, q, r;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 hi", hi_q, 0);
        chk("R1 lo", lo_q, 0);
        chk("R1 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 exhaustive multiply
        for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
                issue(2, a, b);
                p = longint'(a) * longint'(b);
                chk("R3 mulu", {hi_q, lo_q}, p & (M*M - 1));
                chk("R3 busy", busy, 0);
                issue(1, a, b);
                p = sx(a) * sx(b);
                chk("R4 muls", {hi_q, lo_q}, p & (M*M - 1));
            end
        end

        // R5 R6 exhaustive divide
        for (int a = 0; a < M; a++) begin
            for (int b = 1; b < M; b++) begin
                issue(4, a, b);
                wait_idle(n);
                chk("R5 cycles", n, W + 1);
                chk("R5 quot", lo_q, (a / b) % M);
                chk("R5 rem", hi_q, (a % b) % M);
                issue(3, a, b);
                wait_idle(n);
                q = sx(a) / sx(b);
                r = sx(a) % sx(b);
                chk("R6 cycles", n, W + 1);
                chk("R6 quot", lo_q, q & (M - 1));
                chk("R6 rem", hi_q, r & (M - 1));
            end
        end
        // R6 most negative over minus one
        issue(3, M/2, M - 1);
        wait_idle(n);
        chk("R6 ovf quot", lo_q, M/2);
        chk("R6 ovf rem", hi_q, 0);

        // R8 divide by zero, both flavours
        issue(4, 13, 0);
        wait_idle(n);
        chk("R8 divu0", n, W + 1);
        issue(3, 45, 0);
        wait_idle(n);
        chk("R8 divs0", n, W + 1);

        // R7 loads
        issue(5, 21, 0);
        issue(6, 42, 0);
        chk("R7 hi", hi_q, 21);
        chk("R7 lo", lo_q, 42);
        issue(5, 9, 0);
        chk("R7 hi2", hi_q, 9);
        chk("R7 lo kept", lo_q, 42);

        // R10 unused codes
        issue(0, 7, 7);
        chk("R10 code0 hi", hi_q, 9);
        chk("R10 code0 lo", lo_q, 42);
        issue(7, 7, 7);
        chk("R10 code7 hi", hi_q, 9);
        chk("R10 code7 lo", lo_q, 42);

        // R9 R11 ops and reads during a divide
        issue(4, 50, 7);
        rd_req = 1'b1; rd_sel = 1'b1;
        #1;
        chk("R11 stall", rd_stall, 1);
        issue(5, 3, 0);
        chk("R9 hi held", hi_q, 9);
        issue(2, 5, 5);
        chk("R9 lo held", lo_q, 42);
        wait_idle(n);
        chk("R9 quot", lo_q, 7);
        chk("R9 rem", hi_q, 1);
        #1;
        chk("R11 no stall", rd_stall, 0);
        chk("R11 read hi", rd_data, 1);
        rd_sel = 1'b0;
        #1;
        chk("R11 read lo", rd_data, 7);
        rd_req = 1'b0;

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule